// File: doc/BRIEF.md
# SPI real-time clock register slave

This block is an SPI slave that holds the time of day, the date and two control registers behind a sixteen-entry address space. All time fields are kept in BCD, so software reads them as they are and needs no conversion. A one-pulse input (`tickIn`) drives a sub-second prescaler. The time then advances once per second, with full carries from seconds up to the two-digit year and a century flag.

Each transfer begins with one command byte. The upper nibble of that byte is the register address. The lower nibble chooses between a single access and a burst, and between a read and a write. A burst moves an internal pointer forward, so the complete time can be read or written under one chip-select assertion and cannot tear. The hour register runs in either a 24-hour or a 12-hour format. Two input pulses raise sticky status flags: one reports a stopped oscillator and the other reports a low supply voltage. Software clears these flags by writing to the second control register.

Top module: `rtc_spi_slave`

## Requirements
- R1: The command byte carries the address in bits 7:4. Bit 3 selects a single access when 1 and a burst when 0. Bit 2 selects a read when 1 and a write when 0, so 0x8 is a single write, 0xC a single read, 0x0 a burst write and 0x4 a burst read. A single write stores only the first data byte and ignores the bytes after it. A single read returns the same register for every data byte.
- R2: In a burst, the register pointer starts at the command address and steps by one after each data byte. It wraps from 15 to 0.
- R3: The serial clock idles low and chip select is active high. The slave samples MOSI on the falling edge of the serial clock and updates MISO on the rising edge, MSB first. The byte after the command byte returns the addressed register. MISO is 0 while chip select is low.
- R4: The register map is: seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5, year 6, control-A 14, control-B 15. Writes keep only these bits: seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, day 0x3F, month 0x9F. Seconds bit 7 therefore reads 0. Addresses 7 to 13 read 0 and ignore writes.
- R5: After reset the time registers read 00:00:00, weekday 0, day 0x01, month 0x01, year 0x00. Control-A reads 0x20 and control-B reads 0x10.
- R6: The seconds advance once for every TICKS_PER_SEC pulses on `tickIn`. A write to the seconds register restarts this count, so a full second passes before the next advance.
- R7: The seconds carry into the minutes, the minutes into the hours and the hours into the day. Every day carry also steps the weekday, which counts 0 to 6 and then wraps to 0. The day carries into the month and December carries into the year.
- R8: The last day of a month is 0x31, 0x30 for months 4, 6, 9 and 11, and 0x28 for month 2. Month 2 has a last day of 0x29 when the two-digit year is divisible by 4, including year 00.
- R9: The hour format is 24-hour when control-A bit 5 is set and 12-hour when it is clear. In 12-hour mode, hours bit 5 is the PM flag and the hours count 12, 1, …, 11. The hour after 11 AM is 12 PM. The hour after 11 PM is 12 AM, and that step also advances the day.
- R10: Month bit 7 is the century flag. It toggles when the year rolls from 0x99 to 0x00.
- R11: Control-B bit 4 is the oscillator-stop flag, set by a pulse on `oscStopIn`. Control-B bit 6 is the low-voltage flag, set by a pulse on `lowVoltIn`. Both flags stay set until a write to control-B puts 0 in that bit. A 1 written to a flag leaves it unchanged. All other control-B bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI inputs are oversampled by it |
| rstN | input | 1 | Asynchronous active-low reset |
| spiClk | input | 1 | SPI serial clock, idle low |
| spiCs | input | 1 | SPI chip select, active high |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial data to the master |
| tickIn | input | 1 | Single-cycle prescaler tick pulse |
| oscStopIn | input | 1 | Pulse that sets the oscillator-stop flag |
| lowVoltIn | input | 1 | Pulse that sets the low-voltage flag |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4. One second then costs four tick pulses, so the bench can reach year, century and leap-day rollovers, and the prescaler restart, within a few dozen cycles. The bench uses a behavioural calendar kept in binary and compares it with the BCD bytes read back over SPI. Both directed edge dates and seeded random dates are used, with starting seconds biased close to 59 so that carries happen often in both hour formats.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  // command low-nibble bit positions
  localparam int CMD_SINGLE_BIT = 3;
  localparam int CMD_READ_BIT   = 2;

  // register addresses (neighbours decode these)
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'd2;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd3;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'd6;
  localparam logic [ADDR_W-1:0] A_CTLA = 4'd14;
  localparam logic [ADDR_W-1:0] A_CTLB = 4'd15;

  localparam int BIT_H24  = 5;
  localparam int BIT_PM   = 5;
  localparam int BIT_CENT = 7;
  localparam int BIT_OSC  = 4;
  localparam int BIT_LOWV = 6;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [ADDR_W-1:0] rdAddr;
  } regStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month in BCD; leap test uses tens parity and units digit
  function automatic logic [7:0] monthLen(input logic [4:0] mon, input logic [4:0] yrLow);
    logic leap;
    leap = yrLow[4] ? (yrLow[3:0] == 4'd2 || yrLow[3:0] == 4'd6)
                    : (yrLow[3:0] == 4'd0 || yrLow[3:0] == 4'd4 || yrLow[3:0] == 4'd8);
    case (mon)
      5'h02:                      monthLen = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: monthLen = 8'h30;
      default:                    monthLen = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiClk,
  input  logic              spiCs,
  input  logic              spiMosi,
  input  logic [DATA_W-1:0] rdData,
  output regStrobe_t        strobe,
  output logic              spiMiso
);
  localparam int BIT_CNT_W = $clog2(DATA_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(DATA_W - 1);

  logic sclkQ, sclkPrev, csQ, mosiQ;
  logic riseEdge, fallEdge, byteDone;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] rxByte, txShift, nextTx;
  logic [ADDR_W-1:0] ptr, cmdAddr;
  logic cmdPhase, isRead, isSingle, dataSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0; sclkPrev <= 1'b0; csQ <= 1'b0; mosiQ <= 1'b0;
    end else begin
      sclkQ <= spiClk; sclkPrev <= sclkQ; csQ <= spiCs; mosiQ <= spiMosi;
    end
  end

  assign riseEdge = csQ & sclkQ & ~sclkPrev;
  assign fallEdge = csQ & ~sclkQ & sclkPrev;
  assign rxByte   = {rxShift, mosiQ};
  assign byteDone = fallEdge && (bitCnt == LAST_BIT);
  assign cmdAddr  = rxByte[DATA_W-1 -: ADDR_W];

  always_comb begin
    strobe.rdAddr = cmdPhase ? cmdAddr : ptr;
    strobe.wrAddr = ptr;
    strobe.wrData = rxByte;
    strobe.wrEn   = byteDone && !cmdPhase && !isRead && !(isSingle && dataSeen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; rxShift <= '0; txShift <= '0; nextTx <= '0; ptr <= '0;
      cmdPhase <= 1'b1; isRead <= 1'b0; isSingle <= 1'b0; dataSeen <= 1'b0;
    end else if (!csQ) begin
      bitCnt <= '0; txShift <= '0; nextTx <= '0;
      cmdPhase <= 1'b1; isRead <= 1'b0; isSingle <= 1'b0; dataSeen <= 1'b0;
    end else begin
      if (fallEdge) begin
        rxShift <= rxByte[DATA_W-2:0];
        bitCnt  <= bitCnt + 1'b1;
      end
      if (byteDone) begin
        if (cmdPhase) begin
          cmdPhase <= 1'b0;
          isRead   <= rxByte[CMD_READ_BIT];
          isSingle <= rxByte[CMD_SINGLE_BIT];
          ptr      <= cmdAddr + ADDR_W'(rxByte[CMD_READ_BIT] && !rxByte[CMD_SINGLE_BIT]);
          nextTx   <= rxByte[CMD_READ_BIT] ? rdData : '0;
        end else begin
          dataSeen <= 1'b1;
          if (!isSingle) ptr <= ptr + 1'b1;
          nextTx   <= isRead ? rdData : '0;
        end
      end
      if (riseEdge) txShift <= (bitCnt == '0) ? nextTx : {txShift[DATA_W-2:0], 1'b0};
    end
  end

  assign spiMiso = csQ & txShift[DATA_W-1];

  assert_burst_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && byteDone && !cmdPhase && !isSingle) |=> (ptr == $past(ptr) + 1'b1));

  assert_single_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && byteDone && !cmdPhase && isSingle) |=> $stable(ptr));
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_spi_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              tickIn,
  input  logic              oscStopIn,
  input  logic              lowVoltIn,
  output logic [DATA_W-1:0] rdData
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] preCnt;
  logic [7:0] secR, minR, hourR, wdayR, dayR, monR, yearR, ctlAR;
  logic oscFlag, lowvFlag;
  logic wrSec, wrCtlB, h24;
  logic secStep, minStep, hourStep, dayStep, monStep, yearStep, centFlip;
  logic [7:0] secNext, minNext, hourNext, wdayNext, dayNext, monNext, yearNext;

  assign h24    = ctlAR[BIT_H24];
  assign wrSec  = strobe.wrEn && strobe.wrAddr == A_SEC;
  assign wrCtlB = strobe.wrEn && strobe.wrAddr == A_CTLB;

  assign secStep  = tickIn && preCnt == PRE_MAX && !wrSec;
  assign minStep  = secStep && secR == 8'h59;
  assign hourStep = minStep && minR == 8'h59;
  assign dayStep  = hourStep && (h24 ? hourR == 8'h23 : hourR == 8'h31);
  assign monStep  = dayStep && dayR == monthLen(monR[4:0], yearR[4:0]);
  assign yearStep = monStep && monR[4:0] == 5'h12;
  assign centFlip = yearStep && yearR == 8'h99;

  always_comb begin
    secNext  = (secR == 8'h59) ? 8'h00 : (bcdInc(secR) & 8'h7F);
    minNext  = (minR == 8'h59) ? 8'h00 : (bcdInc(minR) & 8'h7F);
    if (h24)                        hourNext = (hourR == 8'h23) ? 8'h00 : (bcdInc(hourR) & 8'h3F);
    else if (hourR[4:0] == 5'h11)   hourNext = {2'b00, ~hourR[BIT_PM], 5'h12};
    else if (hourR[4:0] == 5'h12)   hourNext = {2'b00, hourR[BIT_PM], 5'h01};
    else                            hourNext = {2'b00, hourR[BIT_PM], 5'(bcdInc({3'b000, hourR[4:0]}))};
    wdayNext = (wdayR >= 8'h06) ? 8'h00 : wdayR + 8'h01;
    dayNext  = monStep ? 8'h01 : (bcdInc(dayR) & 8'h3F);
    monNext  = {monR[BIT_CENT] ^ centFlip, 2'b00,
                yearStep ? 5'h01 : 5'(bcdInc({3'b000, monR[4:0]}))};
    yearNext = (yearR == 8'h99) ? 8'h00 : bcdInc(yearR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      secR <= 8'h00; minR <= 8'h00; hourR <= 8'h00; wdayR <= 8'h00;
      dayR <= 8'h01; monR <= 8'h01; yearR <= 8'h00; ctlAR <= 8'h20;
      oscFlag <= 1'b1; lowvFlag <= 1'b0;
    end else begin
      if (wrSec)       preCnt <= '0;
      else if (tickIn) preCnt <= (preCnt == PRE_MAX) ? '0 : preCnt + 1'b1;
      if (secStep)  secR  <= secNext;
      if (minStep)  minR  <= minNext;
      if (hourStep) hourR <= hourNext;
      if (dayStep) begin wdayR <= wdayNext; dayR <= dayNext; end
      if (monStep)  monR  <= monNext;
      if (yearStep) yearR <= yearNext;
      if (strobe.wrEn) begin
        case (strobe.wrAddr)
          A_SEC:  secR  <= strobe.wrData & 8'h7F;
          A_MIN:  minR  <= strobe.wrData & 8'h7F;
          A_HOUR: hourR <= strobe.wrData & 8'h3F;
          A_WDAY: wdayR <= strobe.wrData & 8'h07;
          A_DAY:  dayR  <= strobe.wrData & 8'h3F;
          A_MON:  monR  <= strobe.wrData & 8'h9F;
          A_YEAR: yearR <= strobe.wrData;
          A_CTLA: ctlAR <= strobe.wrData;
          A_CTLB: begin
            oscFlag  <= oscFlag  & strobe.wrData[BIT_OSC];
            lowvFlag <= lowvFlag & strobe.wrData[BIT_LOWV];
          end
          default: ;
        endcase
      end
      if (oscStopIn) oscFlag  <= 1'b1;
      if (lowVoltIn) lowvFlag <= 1'b1;
    end
  end

  always_comb begin
    case (strobe.rdAddr)
      A_SEC:   rdData = secR;
      A_MIN:   rdData = minR;
      A_HOUR:  rdData = hourR;
      A_WDAY:  rdData = wdayR;
      A_DAY:   rdData = dayR;
      A_MON:   rdData = monR;
      A_YEAR:  rdData = yearR;
      A_CTLA:  rdData = ctlAR;
      A_CTLB:  rdData = {1'b0, lowvFlag, 1'b0, oscFlag, 4'b0000};
      default: rdData = '0;
    endcase
  end

  assert_sec_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    secStep |=> (secR != $past(secR)));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (oscFlag && !wrCtlB) |=> oscFlag);

  assert_century_flip_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.wrEn) && monR[BIT_CENT] != $past(monR[BIT_CENT]))
      |-> ($past(yearR) == 8'h99 && yearR == 8'h00));
endmodule

// File: rtl/rtc_spi_slave.sv
module rtc_spi_slave
  import rtc_spi_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiCs,
  input  logic spiMosi,
  output logic spiMiso,
  input  logic tickIn,
  input  logic oscStopIn,
  input  logic lowVoltIn
);
  regStrobe_t        strobe;
  logic [DATA_W-1:0] rdData;

  rtc_spi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCs(spiCs), .spiMosi(spiMosi),
    .rdData(rdData), .strobe(strobe), .spiMiso(spiMiso)
  );

  rtc_time_regs #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tickIn(tickIn),
    .oscStopIn(oscStopIn), .lowVoltIn(lowVoltIn), .rdData(rdData)
  );
endmodule

// File: tb/rtc_spi_slave_tb.sv
module rtc_spi_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 4;
  localparam int HALF = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic spiClk = 1'b0, spiCs = 1'b0, spiMosi = 1'b0, spiMiso;
  logic tickIn = 1'b0, oscStopIn = 1'b0, lowVoltIn = 1'b0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  logic [7:0] txBuf [0:7];
  logic [7:0] rxBuf [0:7];
  int mSec, mMin, mHour, mWday, mDay, mMon, mYear, mCent;
  bit m24;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_spi_slave #(.TICKS_PER_SEC(TICKS)) u_dut (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCs(spiCs), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .tickIn(tickIn), .oscStopIn(oscStopIn), .lowVoltIn(lowVoltIn)
  );

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expByte(input int idx);
    case (idx)
      0: return toBcd(mSec);
      1: return toBcd(mMin);
      2: return m24 ? toBcd(mHour)
                    : (toBcd((mHour + 11) % 12 + 1) | ((mHour >= 12) ? 8'h20 : 8'h00));
      3: return toBcd(mWday);
      4: return toBcd(mDay);
      5: return toBcd(mMon) | (mCent != 0 ? 8'h80 : 8'h00);
      default: return toBcd(mYear);
    endcase
  endfunction

  task automatic modelStep();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0; mWday = (mWday + 1) % 7; mDay++;
          if (mDay > daysIn(mMon, mYear)) begin
            mDay = 1; mMon++;
            if (mMon == 13) begin
              mMon = 1; mYear++;
              if (mYear == 100) begin mYear = 0; mCent ^= 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic checkEq(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic xferByte(input logic [7:0] txb, output logic [7:0] rxb);
    for (int i = 7; i >= 0; i--) begin
      spiClk = 1'b1; spiMosi = txb[i];
      repeat (HALF) @(negedge clk);
      rxb[i] = spiMiso;
      spiClk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic spiTxn(input logic [7:0] cmd, input int nData);
    logic [7:0] r;
    spiCs = 1'b1;
    repeat (4) @(negedge clk);
    xferByte(cmd, r);
    for (int i = 0; i < nData; i++) begin
      xferByte(txBuf[i], r);
      rxBuf[i] = r;
    end
    spiCs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic singleWrite(input logic [3:0] addr, input logic [7:0] data);
    txBuf[0] = data;
    spiTxn({addr, 4'h8}, 1);
  endtask

  task automatic singleRead(input logic [3:0] addr, output logic [7:0] data);
    txBuf[0] = 8'h00;
    spiTxn({addr, 4'hC}, 1);
    data = rxBuf[0];
  endtask

  task automatic pulseTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tickIn = 1'b1; @(negedge clk); tickIn = 1'b0; @(negedge clk);
    end
  endtask

  // loads the model time into the DUT, advances nSec seconds, compares all seven time bytes
  task automatic setAndAdvance(input int h, input int mi, input int s, input int wd, input int d,
                               input int mo, input int y, input int c, input bit mode24,
                               input int nSec, input string tag);
    m24 = mode24;
    singleWrite(4'd14, mode24 ? 8'h20 : 8'h00);
    mHour = h; mMin = mi; mSec = s; mWday = wd; mDay = d; mMon = mo; mYear = y; mCent = c;
    for (int i = 0; i < 7; i++) txBuf[i] = expByte(i);
    spiTxn(8'h00, 7);
    pulseTicks(nSec * TICKS);
    for (int i = 0; i < nSec; i++) modelStep();
    for (int i = 0; i < 8; i++) txBuf[i] = 8'h00;
    spiTxn(8'h04, 7);
    for (int i = 0; i < 7; i++) checkEq(tag, $sformatf("time byte %0d", i), rxBuf[i], expByte(i));
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin txBuf[i] = 8'h00; rxBuf[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3: MISO quiet while chip select is low
    checkEq("R3", "miso idle", {7'b0, spiMiso}, 8'h00);

    // R5: reset contents via a burst read from address 0
    spiTxn(8'h04, 7);
    checkEq("R5", "reset sec",  rxBuf[0], 8'h00);
    checkEq("R5", "reset hour", rxBuf[2], 8'h00);
    checkEq("R5", "reset day",  rxBuf[4], 8'h01);
    checkEq("R5", "reset mon",  rxBuf[5], 8'h01);
    checkEq("R5", "reset year", rxBuf[6], 8'h00);
    singleRead(4'd14, v); checkEq("R5", "reset ctlA", v, 8'h20);
    singleRead(4'd15, v); checkEq("R5", "reset ctlB", v, 8'h10);

    // R4: masks and reserved addresses
    singleWrite(4'd0, 8'hD5);  singleRead(4'd0, v); checkEq("R4", "sec bit7 masked", v, 8'h55);
    singleWrite(4'd2, 8'hFF);  singleRead(4'd2, v); checkEq("R4", "hour mask", v, 8'h3F);
    singleWrite(4'd5, 8'hFF);  singleRead(4'd5, v); checkEq("R4", "month mask", v, 8'h9F);
    singleWrite(4'd9, 8'hA5);  singleRead(4'd9, v); checkEq("R4", "reserved reads 0", v, 8'h00);
    singleWrite(4'd5, 8'h01);

    // R1: single write keeps only the first data byte
    txBuf[0] = 8'h12; txBuf[1] = 8'h34; txBuf[2] = 8'h56;
    spiTxn(8'h18, 3);
    singleRead(4'd1, v); checkEq("R1", "single write first byte", v, 8'h12);
    singleRead(4'd2, v); checkEq("R1", "hour untouched", v, 8'h3F);
    singleRead(4'd0, v); checkEq("R1", "sec untouched", v, 8'h55);
    // R1: single read repeats the same register
    singleWrite(4'd3, 8'h05);
    for (int i = 0; i < 3; i++) txBuf[i] = 8'h00;
    spiTxn(8'h3C, 3);
    for (int i = 0; i < 3; i++) checkEq("R1", "single read repeat", rxBuf[i], 8'h05);

    // R2: burst write from 14 wraps to 0 and 1; R3 burst read back
    txBuf[0] = 8'h20; txBuf[1] = 8'h00; txBuf[2] = 8'h33; txBuf[3] = 8'h44;
    spiTxn(8'hE0, 4);
    for (int i = 0; i < 4; i++) txBuf[i] = 8'h00;
    spiTxn(8'hE4, 4);
    checkEq("R2", "wrap ctlA", rxBuf[0], 8'h20);
    checkEq("R2", "wrap ctlB cleared", rxBuf[1], 8'h00);
    checkEq("R2", "wrap sec", rxBuf[2], 8'h33);
    checkEq("R3", "wrap min", rxBuf[3], 8'h44);

    // R11: sticky flags
    oscStopIn = 1'b1; @(negedge clk); oscStopIn = 1'b0; @(negedge clk);
    singleRead(4'd15, v); checkEq("R11", "osc flag set", v, 8'h10);
    lowVoltIn = 1'b1; @(negedge clk); lowVoltIn = 1'b0; @(negedge clk);
    singleRead(4'd15, v); checkEq("R11", "both flags", v, 8'h50);
    singleWrite(4'd15, 8'h10); singleRead(4'd15, v); checkEq("R11", "clear low-volt only", v, 8'h10);
    singleWrite(4'd15, 8'h00); singleRead(4'd15, v); checkEq("R11", "clear all", v, 8'h00);

    // R6: prescaler restarts on a seconds write
    singleWrite(4'd0, 8'h30); pulseTicks(TICKS - 1);
    singleRead(4'd0, v); checkEq("R6", "no step before full count", v, 8'h30);
    singleWrite(4'd0, 8'h30); pulseTicks(TICKS - 1);
    singleRead(4'd0, v); checkEq("R6", "restart after write", v, 8'h30);
    pulseTicks(1);
    singleRead(4'd0, v); checkEq("R6", "step at full count", v, 8'h31);

    // R7 / R10: full carry chain and century
    setAndAdvance(23, 59, 59, 6, 31, 12, 99, 0, 1'b1, 1, "R10");
    setAndAdvance(23, 59, 59, 3, 31, 12, 99, 1, 1'b1, 1, "R10");
    setAndAdvance(10, 20, 57, 2, 15,  6, 45, 0, 1'b1, 4, "R7");
    // R8: month lengths and leap years
    setAndAdvance(23, 59, 59, 1, 28, 2, 24, 1, 1'b1, 1, "R8");
    setAndAdvance(23, 59, 59, 1, 28, 2, 23, 1, 1'b1, 1, "R8");
    setAndAdvance(23, 59, 59, 1, 29, 2,  0, 1, 1'b1, 1, "R8");
    setAndAdvance(23, 59, 59, 1, 30, 4, 10, 0, 1'b1, 1, "R8");
    setAndAdvance(23, 59, 59, 1, 31, 1, 10, 0, 1'b1, 1, "R8");
    // R9: 12-hour format
    setAndAdvance(11, 59, 59, 0, 10, 3, 20, 1, 1'b0, 1, "R9");
    setAndAdvance(23, 59, 59, 0, 10, 3, 20, 1, 1'b0, 1, "R9");
    setAndAdvance( 0, 59, 59, 0, 10, 3, 20, 1, 1'b0, 1, "R9");
    setAndAdvance(12, 59, 59, 0, 10, 3, 20, 1, 1'b0, 1, "R9");

    // R7: seeded random dates biased toward carries, both formats
    for (int it = 0; it < 40; it++) begin
      int mo, y, d;
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 100);
      d  = ($urandom % 2) ? daysIn(mo, y) : 1 + int'($urandom % daysIn(mo, y));
      setAndAdvance(int'($urandom % 24), ($urandom % 2) ? 59 : int'($urandom % 60),
                    50 + int'($urandom % 10), int'($urandom % 7), d, mo, y,
                    int'($urandom % 2), 1'($urandom % 2), 1 + int'($urandom % 10), "R7");
    end

    finished = 1'b1;
    report();
    $finish;
  end
endmodule